// File: doc/BRIEF.md
# Circuit-Switched Streaming Switch Node

This block is one node in a linear chain of switches that lets hardware modules exchange data streams. Each node serves one local module and passes traffic to its neighbours over two independent channel groups: channels that run toward higher node numbers (rightward) and channels that run toward lower node numbers (leftward). Each group has its own parameterised channel count.

A stream opens with a header word that names the destination node. The node compares that index with its own and claims a free output channel: the local port, a rightward channel or a leftward channel. From then on the input is tied to that output. Every later word passes straight through with valid/ready handshakes, and backpressure travels back along the held path. The circuit stays open until the word carrying the end flag is accepted downstream. The output is then free again in the next cycle.

Every input port runs a three-state controller. `ST_IDLE` waits for a header. Idle goes to `ST_FWD` when the header is granted in the cycle it arrives, and to `ST_WAIT` when no channel in its group is free. `ST_WAIT` moves to `ST_FWD` on a grant, or back to `ST_IDLE` if valid drops. `ST_FWD` returns to `ST_IDLE` when the end word is handed over. An allocator holds one busy bit per output and grants in fixed input order. A crossbar steers data and valid from each forwarding input to its claimed output.

Top module: `ssn_node`

## Requirements
- R1: A channel word is DATA_W+2 bits wide. Bit DATA_W+1 is the header flag, bit DATA_W is the end flag, and a header's destination index sits in bits NODE_W-1:0. Every word, including the header, leaves the node unchanged.
- R2: A header whose destination equals NODE_ID goes to the local output. A larger destination goes to a rightward output, and a smaller one goes to a leftward output, whichever input the header arrived on.
- R3: Within the required group, the lowest-numbered free channel is claimed.
- R4: A header arriving at an idle input whose target group has a free channel appears valid on the output in the following cycle. This is well within the 10-cycle setup limit.
- R5: After setup, every word of the stream leaves on the same output, in order, with none lost, duplicated or re-routed. A set header flag inside an open circuit is treated as data.
- R6: A word moves only when valid and ready are both high. While a circuit is open, the input's ready equals the ready of its claimed output. A stalled output holds its data stable.
- R7: If every channel in the required group is busy, the header is held with ready low. It is not dropped, and it is granted once a channel frees.
- R8: When several inputs compete in one cycle, the local input wins first, then the rightward inputs in channel order, then the leftward inputs in channel order.
- R9: In the cycle after the end word is accepted downstream, the output's valid is low and the channel can be granted. A waiting header therefore appears on it two cycles after the end word's transfer cycle.
- R10: A word without the header flag that arrives at an idle input is accepted and discarded.
- R11: An active-low asynchronous reset releases all circuits and drives all output valids low.
- R12: A single word carrying both the header flag and the end flag opens a circuit and closes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_in_data | input | DATA_W+2 | Word from the local module |
| loc_in_valid | input | 1 | Local input word valid |
| loc_in_ready | output | 1 | Local input word accepted |
| loc_out_data | output | DATA_W+2 | Word to the local module |
| loc_out_valid | output | 1 | Local output valid |
| loc_out_ready | input | 1 | Local module can accept |
| rw_in_data | input | N_R*(DATA_W+2) | Rightward channels arriving from the left neighbour |
| rw_in_valid | input | N_R | Valid per arriving rightward channel |
| rw_in_ready | output | N_R | Ready per arriving rightward channel |
| rw_out_data | output | N_R*(DATA_W+2) | Rightward channels toward the right neighbour |
| rw_out_valid | output | N_R | Valid per outgoing rightward channel |
| rw_out_ready | input | N_R | Ready per outgoing rightward channel |
| lw_in_data | input | N_L*(DATA_W+2) | Leftward channels arriving from the right neighbour |
| lw_in_valid | input | N_L | Valid per arriving leftward channel |
| lw_in_ready | output | N_L | Ready per arriving leftward channel |
| lw_out_data | output | N_L*(DATA_W+2) | Leftward channels toward the left neighbour |
| lw_out_valid | output | N_L | Valid per outgoing leftward channel |
| lw_out_ready | input | N_L | Ready per outgoing leftward channel |

## Verification
The node under test sits at index 3 with two channels each way.

- **Destination sweep.** Streams are sent from every input kind to destinations below, equal to and above the node index, with all of them open at once. This separates the three routing outcomes and shows the one-cycle setup latency.
- **Contention.** Three headers competing for two rightward channels, and three competing for the single local output, show the claimed channel, the grant order and the exact cycle a freed channel is reused.
- **Backpressure.** A periodic stall pattern on the outputs checks that payloads arrive in order with no loss.
- **Corner cases.** A stray data word on an idle input, single-word streams, and a reset that cuts two open circuits show discard, immediate teardown and release.

// File: rtl/ssn_pkg.sv
package ssn_pkg;

    // controller state of one input port
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FWD  = 2'd2
    } port_state_t;

    // which output group a header asks for
    typedef enum logic [1:0] {
        GRP_LOC = 2'd0,
        GRP_RGT = 2'd1,
        GRP_LFT = 2'd2
    } out_grp_t;

endpackage

// File: rtl/ssn_in_port.sv
module ssn_in_port
    import ssn_pkg::*;
#(
    parameter int NODE_W  = 4,
    parameter int NODE_ID = 1,
    parameter int NO      = 5,
    localparam int OW     = $clog2(NO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_hdr,
    input  logic              in_end,
    input  logic [NODE_W-1:0] in_dest,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NO-1:0]     out_ready,
    output logic              req,
    output out_grp_t          req_grp,
    input  logic              grant,
    input  logic [OW-1:0]     grant_idx,
    output logic              fwd,
    output logic [OW-1:0]     sel
);

    port_state_t state, state_nx;
    logic [OW-1:0] sel_q;

    // direction from the sign of destination minus own index
    always_comb begin
        if (in_dest == NODE_W'(NODE_ID))
            req_grp = GRP_LOC;
        else if (in_dest > NODE_W'(NODE_ID))
            req_grp = GRP_RGT;
        else
            req_grp = GRP_LFT;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && in_hdr)
                    state_nx = grant ? ST_FWD : ST_WAIT;
            end
            ST_WAIT: begin
                if (!in_valid)
                    state_nx = ST_IDLE;
                else if (grant)
                    state_nx = ST_FWD;
            end
            ST_FWD: begin
                if (in_valid && in_ready && in_end)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= '0;
        end else begin
            state <= state_nx;
            if (grant)
                sel_q <= grant_idx;
        end
    end

    // outputs
    always_comb begin
        req      = 1'b0;
        in_ready = 1'b0;
        fwd      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req      = in_valid && in_hdr;
                in_ready = in_valid && !in_hdr;   // stray word: discard
            end
            ST_WAIT: begin
                req      = in_valid && in_hdr;
            end
            ST_FWD: begin
                fwd      = 1'b1;
                in_ready = out_ready[sel_q];
            end
            default: begin
                req      = 1'b0;
            end
        endcase
    end

    assign sel = sel_q;

endmodule

// File: rtl/ssn_alloc.sv
module ssn_alloc
    import ssn_pkg::*;
#(
    parameter int NI  = 5,
    parameter int NO  = 5,
    parameter int N_R = 2,
    parameter int N_L = 2,
    localparam int OW = $clog2(NO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NI-1:0]    req,
    input  logic [2*NI-1:0]  req_grp,
    input  logic [NO-1:0]    rel,
    output logic [NI-1:0]    grant,
    output logic [NI*OW-1:0] grant_idx,
    output logic [NO-1:0]    busy
);

    logic [NO-1:0] claim;

    function automatic logic member(input int o, input out_grp_t g);
        logic r;
        unique case (g)
            GRP_LOC: r = (o == 0);
            GRP_RGT: r = (o >= 1) && (o <= N_R);
            GRP_LFT: r = (o > N_R) && (o <= N_R + N_L);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // fixed priority: lower input index claims first
    always_comb begin
        logic [NO-1:0] taken;
        logic          found;
        taken     = busy;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < NI; i++) begin
            found = 1'b0;
            if (req[i]) begin
                for (int o = 0; o < NO; o++) begin
                    if (!found && !taken[o] && member(o, out_grp_t'(req_grp[2*i +: 2]))) begin
                        found                  = 1'b1;
                        taken[o]               = 1'b1;
                        grant[i]               = 1'b1;
                        grant_idx[i*OW +: OW]  = OW'(o);
                    end
                end
            end
        end
        claim = taken & ~busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy <= '0;
        else
            busy <= (busy & ~rel) | claim;
    end

endmodule

// File: rtl/ssn_xbar.sv
module ssn_xbar #(
    parameter int NI  = 5,
    parameter int NO  = 5,
    parameter int FW  = 34,
    localparam int OW = $clog2(NO)
) (
    input  logic [NI*FW-1:0] in_data,
    input  logic [NI-1:0]    in_valid,
    input  logic [NI-1:0]    fwd,
    input  logic [NI*OW-1:0] sel,
    output logic [NO*FW-1:0] out_data,
    output logic [NO-1:0]    out_valid
);

    for (genvar o = 0; o < NO; o++) begin : g_out
        always_comb begin
            out_valid[o]          = 1'b0;
            out_data[o*FW +: FW]  = '0;
            for (int i = 0; i < NI; i++) begin
                if (fwd[i] && (sel[i*OW +: OW] == OW'(o))) begin
                    out_valid[o]         = in_valid[i];
                    out_data[o*FW +: FW] = in_data[i*FW +: FW];
                end
            end
        end
    end

endmodule

// File: rtl/ssn_node.sv
module ssn_node
    import ssn_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NODE_W  = 4,
    parameter int N_R     = 2,
    parameter int N_L     = 2,
    parameter int NODE_ID = 1,
    localparam int FW     = DATA_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FW-1:0]      loc_in_data,
    input  logic               loc_in_valid,
    output logic               loc_in_ready,
    output logic [FW-1:0]      loc_out_data,
    output logic               loc_out_valid,
    input  logic               loc_out_ready,
    input  logic [N_R*FW-1:0]  rw_in_data,
    input  logic [N_R-1:0]     rw_in_valid,
    output logic [N_R-1:0]     rw_in_ready,
    output logic [N_R*FW-1:0]  rw_out_data,
    output logic [N_R-1:0]     rw_out_valid,
    input  logic [N_R-1:0]     rw_out_ready,
    input  logic [N_L*FW-1:0]  lw_in_data,
    input  logic [N_L-1:0]     lw_in_valid,
    output logic [N_L-1:0]     lw_in_ready,
    output logic [N_L*FW-1:0]  lw_out_data,
    output logic [N_L-1:0]     lw_out_valid,
    input  logic [N_L-1:0]     lw_out_ready
);

    localparam int NI = 1 + N_R + N_L;
    localparam int NO = 1 + N_R + N_L;
    localparam int OW = $clog2(NO);
    localparam int HB = FW - 1;
    localparam int EB = FW - 2;

    // index 0 local, then rightward, then leftward
    logic [NI*FW-1:0] a_in_data;
    logic [NI-1:0]    a_in_valid;
    logic [NI-1:0]    a_in_ready;
    logic [NO*FW-1:0] a_out_data;
    logic [NO-1:0]    a_out_valid;
    logic [NO-1:0]    a_out_ready;

    logic [NI-1:0]    req, grant, fwd;
    logic [2*NI-1:0]  req_grp;
    logic [NI*OW-1:0] grant_idx, sel;
    logic [NO-1:0]    rel, busy;

    assign a_in_data   = {lw_in_data, rw_in_data, loc_in_data};
    assign a_in_valid  = {lw_in_valid, rw_in_valid, loc_in_valid};
    assign a_out_ready = {lw_out_ready, rw_out_ready, loc_out_ready};

    assign {lw_in_ready, rw_in_ready, loc_in_ready}    = a_in_ready;
    assign {lw_out_data, rw_out_data, loc_out_data}    = a_out_data;
    assign {lw_out_valid, rw_out_valid, loc_out_valid} = a_out_valid;

    for (genvar i = 0; i < NI; i++) begin : g_port
        out_grp_t grp;
        ssn_in_port #(
            .NODE_W  (NODE_W),
            .NODE_ID (NODE_ID),
            .NO      (NO)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_hdr    (a_in_data[i*FW + HB]),
            .in_end    (a_in_data[i*FW + EB]),
            .in_dest   (a_in_data[i*FW +: NODE_W]),
            .in_valid  (a_in_valid[i]),
            .in_ready  (a_in_ready[i]),
            .out_ready (a_out_ready),
            .req       (req[i]),
            .req_grp   (grp),
            .grant     (grant[i]),
            .grant_idx (grant_idx[i*OW +: OW]),
            .fwd       (fwd[i]),
            .sel       (sel[i*OW +: OW])
        );
        assign req_grp[2*i +: 2] = grp;
    end

    // an output is freed once its end word is handed over
    for (genvar o = 0; o < NO; o++) begin : g_rel
        assign rel[o] = a_out_valid[o] & a_out_ready[o] & a_out_data[o*FW + EB];
    end

    ssn_alloc #(
        .NI  (NI),
        .NO  (NO),
        .N_R (N_R),
        .N_L (N_L)
    ) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_grp   (req_grp),
        .rel       (rel),
        .grant     (grant),
        .grant_idx (grant_idx),
        .busy      (busy)
    );

    ssn_xbar #(
        .NI (NI),
        .NO (NO),
        .FW (FW)
    ) u_xbar (
        .in_data   (a_in_data),
        .in_valid  (a_in_valid),
        .fwd       (fwd),
        .sel       (sel),
        .out_data  (a_out_data),
        .out_valid (a_out_valid)
    );

endmodule

// File: rtl/ssn_node_chk.sv
module ssn_node_chk #(
    parameter int DATA_W  = 32,
    parameter int NODE_W  = 4,
    parameter int N_R     = 2,
    parameter int N_L     = 2,
    parameter int NODE_ID = 1,
    localparam int FW     = DATA_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_in_valid,
    input logic              loc_in_ready,
    input logic [FW-1:0]     loc_out_data,
    input logic              loc_out_valid,
    input logic              loc_out_ready,
    input logic [N_R-1:0]    rw_in_valid,
    input logic [N_R-1:0]    rw_in_ready,
    input logic [N_R*FW-1:0] rw_out_data,
    input logic [N_R-1:0]    rw_out_valid,
    input logic [N_R-1:0]    rw_out_ready,
    input logic [N_L-1:0]    lw_in_valid,
    input logic [N_L-1:0]    lw_in_ready,
    input logic [N_L*FW-1:0] lw_out_data,
    input logic [N_L-1:0]    lw_out_valid,
    input logic [N_L-1:0]    lw_out_ready
);

    localparam int NO = 1 + N_R + N_L;

    logic [NO*FW-1:0] od;
    logic [NO-1:0]    ov, ordy;
    logic [NO-1:0]    iv, irdy;

    assign od   = {lw_out_data, rw_out_data, loc_out_data};
    assign ov   = {lw_out_valid, rw_out_valid, loc_out_valid};
    assign ordy = {lw_out_ready, rw_out_ready, loc_out_ready};
    assign iv   = {lw_in_valid, rw_in_valid, loc_in_valid};
    assign irdy = {lw_in_ready, rw_in_ready, loc_in_ready};

    // R11: valids are low once reset has been seen at an edge
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (ov == '0));

    // R5: no output transfer without a matching input transfer
    p_no_spawn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ov & ordy) <= $countones(iv & irdy));

    for (genvar o = 0; o < NO; o++) begin : g_o
        // R6: a stalled output keeps its word
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ov[o] && !ordy[o]) |=> (ov[o] && $stable(od[o*FW +: FW])));

        // R9: output is quiet the cycle after its end word
        p_teardown_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ov[o] && ordy[o] && od[o*FW + FW - 2]) |=> !ov[o]);

        // R2: headers leave on the group matching their destination
        if (o == 0) begin : g_loc
            p_route_loc_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (ov[o] && od[o*FW + FW - 1]) |->
                    (od[o*FW +: NODE_W] == NODE_W'(NODE_ID)));
        end else if (o <= N_R) begin : g_rgt
            p_route_rgt_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (ov[o] && od[o*FW + FW - 1]) |->
                    (od[o*FW +: NODE_W] > NODE_W'(NODE_ID)));
        end else begin : g_lft
            p_route_lft_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (ov[o] && od[o*FW + FW - 1]) |->
                    (od[o*FW +: NODE_W] < NODE_W'(NODE_ID)));
        end
    end

endmodule

bind ssn_node ssn_node_chk #(
    .DATA_W  (DATA_W),
    .NODE_W  (NODE_W),
    .N_R     (N_R),
    .N_L     (N_L),
    .NODE_ID (NODE_ID)
) u_chk (.*);

// File: tb/sim_ssn_node.sv
module sim_ssn_node;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 32;
    localparam int NW = 3;
    localparam int ID = 3;
    localparam int FW = DW + 2;
    localparam int NP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   stall = 1'b0;

    logic [FW-1:0] din [NP];
    logic [NP-1:0] vin = '0;
    wire  [NP-1:0] rin;
    wire  [FW-1:0] dout [NP];
    wire  [NP-1:0] vout;
    logic [NP-1:0] rout = '1;
    wire  [2*FW-1:0] rw_od, lw_od;

    logic [FW-1:0] mdat [NP][64];
    int   mcyc [NP][64];
    int   mcnt [NP];
    int   t_req [64];
    int   t_hdr [64];
    int   t_end [64];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ssn_node #(.DATA_W(DW), .NODE_W(NW), .N_R(2), .N_L(2), .NODE_ID(ID)) u0 (
        .clk(clk), .rst_n(rst_n),
        .loc_in_data(din[0]), .loc_in_valid(vin[0]), .loc_in_ready(rin[0]),
        .loc_out_data(dout[0]), .loc_out_valid(vout[0]), .loc_out_ready(rout[0]),
        .rw_in_data({din[2], din[1]}), .rw_in_valid(vin[2:1]), .rw_in_ready(rin[2:1]),
        .rw_out_data(rw_od), .rw_out_valid(vout[2:1]), .rw_out_ready(rout[2:1]),
        .lw_in_data({din[4], din[3]}), .lw_in_valid(vin[4:3]), .lw_in_ready(rin[4:3]),
        .lw_out_data(lw_od), .lw_out_valid(vout[4:3]), .lw_out_ready(rout[4:3])
    );
    assign dout[1] = rw_od[FW-1:0];
    assign dout[2] = rw_od[2*FW-1:FW];
    assign dout[3] = lw_od[FW-1:0];
    assign dout[4] = lw_od[2*FW-1:FW];

    // output readiness: always ready, or a periodic stall pattern
    always begin
        @(posedge clk); #1;
        for (int o = 0; o < NP; o++)
            rout[o] = stall ? (((cyc + o) % 3) != 0) : 1'b1;
    end

    // monitor: a transfer seen at the falling edge completes at the next rising edge
    always @(negedge clk) begin
        for (int o = 0; o < NP; o++) begin
            if (rst_n && vout[o] && rout[o] && mcnt[o] < 64) begin
                mdat[o][mcnt[o]] = dout[o];
                mcyc[o][mcnt[o]] = cyc;
                mcnt[o]++;
            end
        end
    end

    function automatic logic [FW-1:0] mkw(input bit h, input bit e, input int d);
        return {h, e, DW'(d)};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        for (int o = 0; o < NP; o++) mcnt[o] = 0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic send_word(input int p, input logic [FW-1:0] w, output int c0);
        bit f;
        bit first;
        first = 1'b1;
        din[p] = w;
        vin[p] = 1'b1;
        do begin
            @(negedge clk);
            if (first) c0 = cyc;
            first = 1'b0;
            f = rin[p];
            @(posedge clk); #1;
        end while (!f);
        vin[p] = 1'b0;
    endtask

    // header plus len payload words; the last word carries the end flag
    task automatic send_stream(input int p, input int tag, input int dest, input int len);
        int c;
        send_word(p, mkw(1'b1, len == 0, (tag << 8) | dest), c);
        t_req[tag] = c;
        for (int k = 1; k <= len; k++)
            send_word(p, mkw(1'b0, k == len, (tag << 8) | k), c);
    endtask

    task automatic verify(input string rq, input int tag, input int dest,
                          input int o, input int len);
        int j;
        int bad;
        j = -1;
        for (int k = 0; k < mcnt[o]; k++)
            if (j < 0 && mdat[o][k][FW-1] && mdat[o][k][15:8] == 8'(tag)) j = k;
        chk(j >= 0, rq, $sformatf("stream %0d header on output", tag), j >= 0 ? o : -1, o);
        if (j >= 0) begin
            t_hdr[tag] = mcyc[o][j];
            bad = (mdat[o][j] != mkw(1'b1, len == 0, (tag << 8) | dest)) ? 1 : 0;
            for (int k = 1; k <= len; k++)
                if (j + k >= mcnt[o] || mdat[o][j + k] != mkw(1'b0, k == len, (tag << 8) | k))
                    bad++;
            chk(bad == 0, rq, $sformatf("stream %0d words in order (bad words)", tag), bad, 0);
            t_end[tag] = (j + len < mcnt[o]) ? mcyc[o][j + len] : -1;
        end
    endtask

    function automatic int hpos(input int o, input int tag);
        for (int k = 0; k < mcnt[o]; k++)
            if (mdat[o][k][FW-1] && mdat[o][k][15:8] == 8'(tag)) return k;
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run ended by timeout", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int c;
        int tot;
        for (int p = 0; p < NP; p++) din[p] = '0;
        clear_mon();
        repeat (4) @(posedge clk);
        #1;
        // R11: quiet after reset
        @(negedge clk);
        chk(vout == '0, "R11", "output valids during reset", int'(vout), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        settle();
        chk(vout == '0 && rin == '0, "R11", "valids and readies idle after reset",
            int'({vout, rin}), 0);

        // R1 R2 R3 R4 R5: destination sweep, all streams open together
        clear_mon();
        fork
            send_stream(0, 1, 5, 3);
            send_stream(1, 2, 6, 4);
            send_stream(3, 3, 1, 3);
            send_stream(2, 4, 3, 2);
            send_stream(4, 5, 0, 2);
        join
        settle();
        verify("R2 R3", 1, 5, 1, 3);
        verify("R2 R3", 2, 6, 2, 4);
        verify("R2", 3, 1, 3, 3);
        verify("R2 R1", 4, 3, 0, 2);
        verify("R2 R3", 5, 0, 4, 2);
        chk(t_hdr[1] - t_req[1] == 1, "R4", "setup latency local", t_hdr[1] - t_req[1], 1);
        chk(t_hdr[2] - t_req[2] == 1, "R4", "setup latency rightward", t_hdr[2] - t_req[2], 1);
        chk(t_hdr[5] - t_req[5] == 1, "R4", "setup latency leftward", t_hdr[5] - t_req[5], 1);

        // R7 R8 R9: three headers for two rightward channels
        clear_mon();
        fork
            send_stream(0, 10, 7, 2);
            send_stream(1, 11, 4, 6);
            send_stream(3, 12, 5, 3);
        join
        settle();
        verify("R8", 10, 7, 1, 2);
        verify("R8", 11, 4, 2, 6);
        verify("R7 R9", 12, 5, 1, 3);
        chk(t_hdr[12] - t_end[10] == 2, "R9", "reuse gap after end word",
            t_hdr[12] - t_end[10], 2);
        chk(t_hdr[12] - t_req[12] > 1, "R7", "blocked header waited", t_hdr[12] - t_req[12], 5);

        // R8: three headers for the single local output
        clear_mon();
        fork
            send_stream(4, 22, 3, 1);
            send_stream(2, 21, 3, 1);
            send_stream(0, 20, 3, 1);
        join
        settle();
        verify("R8", 20, 3, 0, 1);
        verify("R8", 21, 3, 0, 1);
        verify("R8", 22, 3, 0, 1);
        chk(hpos(0, 20) == 0 && hpos(0, 21) == 2 && hpos(0, 22) == 4, "R8",
            "local grant order (pos of 2nd,3rd)", hpos(0, 21) * 10 + hpos(0, 22), 24);

        // R6 R5: backpressure with periodic stalls
        clear_mon();
        stall = 1'b1;
        fork
            send_stream(0, 30, 0, 8);
            send_stream(1, 31, 2, 8);
            send_stream(2, 32, 7, 8);
        join
        settle();
        stall = 1'b0;
        verify("R6 R5", 30, 0, 3, 8);
        verify("R6 R5", 31, 2, 4, 8);
        verify("R6 R5", 32, 7, 1, 8);

        // R10: stray word discarded, then a normal stream
        clear_mon();
        send_word(4, mkw(1'b0, 1'b0, 32'h0000_AB06), c);
        settle();
        tot = mcnt[0] + mcnt[1] + mcnt[2] + mcnt[3] + mcnt[4];
        chk(tot == 0, "R10", "words emitted for stray word", tot, 0);
        send_stream(4, 40, 6, 2);
        settle();
        verify("R10", 40, 6, 1, 2);
        chk(mcnt[1] == 3, "R10", "words on rightward channel 0", mcnt[1], 3);

        // R12: single-word streams open and close a circuit
        clear_mon();
        send_stream(0, 50, 4, 0);
        send_stream(3, 51, 6, 0);
        settle();
        verify("R12", 50, 4, 1, 0);
        verify("R12", 51, 6, 1, 0);
        chk(mcnt[1] == 2 && mcnt[2] == 0, "R12", "channel reuse words ch0/ch1",
            mcnt[1] * 10 + mcnt[2], 20);

        // R11: reset cuts two open circuits
        send_word(0, mkw(1'b1, 1'b0, (60 << 8) | 5), c);
        send_word(0, mkw(1'b0, 1'b0, (60 << 8) | 1), c);
        send_word(1, mkw(1'b1, 1'b0, (61 << 8) | 6), c);
        din[0] = mkw(1'b0, 1'b0, 7);
        din[1] = mkw(1'b0, 1'b0, 7);
        vin[1:0] = 2'b11;
        @(negedge clk);
        chk(vout[2:1] == 2'b11, "R5", "open circuits forward data", int'(vout[2:1]), 3);
        @(posedge clk); #1;
        rst_n = 1'b0;
        vin = '0;
        @(negedge clk);
        chk(vout == '0, "R11", "valids in reset", int'(vout), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        clear_mon();
        fork
            send_stream(3, 62, 5, 1);
            send_stream(4, 63, 7, 1);
        join
        settle();
        verify("R11", 62, 5, 1, 1);
        verify("R11", 63, 7, 2, 1);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule